// File: doc/BRIEF.md
# Branch Tag Register Unit

This block keeps the tag state that backs forward control-flow-integrity checking on a RISC-V integer pipeline. It watches each retiring 32-bit instruction word and picks out two hint encodings that the base architecture already defines as no-ops. One hint stores an 8-bit tag into one of four slots. The other hint compares an 8-bit tag with one slot and reports whether the two agree.

Compiled code uses the store hint before an indirect call or jump and the compare hint at the landing point. Each slot can hold a separate rule, so one register can carry several rules at once, for example a function-type tag in one slot and a code-region tag in another. A failed compare raises a request for an illegal-instruction trap, and the pipeline's trap logic takes it from there. The full 32-bit register is shown on a read-only output so that it can appear as a CSR view. No general arithmetic or memory path can write it.

Top module: `btag_unit`

## Requirements
- R1: A synchronous active-high reset clears all four slots to 0x00 and holds `chk_pass` and `chk_fail` low.
- R2: A set is opcode 0010011, funct3 001, funct7 0000000, rd 0. It writes its value into the slot named by its id, and the other three slots keep their values. Slot k occupies `tag_csr` bits 8k+7 down to 8k, and the write shows on `tag_csr` in the cycle after the instruction is presented.
- R3: A check is opcode 0010011, funct3 101, funct7 0000000, rd 0. When its value equals the selected slot, `chk_pass` is high for exactly the next cycle and `chk_fail` stays low.
- R4: A check whose value differs from the selected slot drives `chk_fail` high for exactly the next cycle, keeps `chk_pass` low and leaves every slot unchanged.
- R5: The block ignores a shift whose rd is not 0, a shift whose funct7 is not zero (this includes the arithmetic right shift), and any other opcode. Such an instruction writes no slot and produces neither pulse.
- R6: While `ext_en` is low, both hints are no-ops: no slot is written and neither pulse appears.
- R7: When `retire_valid` is low, the instruction word has no effect.
- R8: A check presented in the cycle right after a set to the same slot compares against the newly written value.
- R9: The id is taken from instruction bits 24:23. The tag value is {bits 22:20, bits 19:15}, with bits 22:20 as the value's upper three bits.
- R10: `chk_pass` and `chk_fail` are never high together, and either one can be high only in the cycle after a valid, enabled check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables the tag hints; when low they are plain no-ops |
| retire_valid | input | 1 | The instruction word is retiring this cycle |
| retire_instr | input | 32 | Retiring instruction word |
| chk_pass | output | 1 | One-cycle pulse for a matching check |
| chk_fail | output | 1 | One-cycle illegal-instruction request for a mismatching check |
| tag_csr | output | 32 | Read-only view of the four tag slots |

## Verification
The bench first writes distinct values into different slots and reads the whole register back. This separates a correct per-slot write from one that spills into a neighbouring slot or lands in the wrong one. It then runs checks against stored values and against stale values, including a check placed right after a set to the same slot. These tell a real compare apart from a constant result and show whether the compare reads the register before or after the write. Near-miss encodings come next: a non-zero rd, a non-zero funct7, a different opcode, enable low and valid low. Where a recognised hint would have changed state, each of these is chosen so that the output would show it, which catches loose decoding. The tag 0xA5 has different bit patterns in its upper three and lower five bits, so it exposes a wrong operand split.

// File: rtl/btag_pkg.sv
package btag_pkg;

   // Fixed instruction fields of the two hint encodings
   localparam logic [6:0] OPC_IMM      = 7'b0010011;
   localparam logic [2:0] F3_SET       = 3'b001;
   localparam logic [2:0] F3_CHECK     = 3'b101;
   localparam logic [6:0] F7_PLAIN     = 7'b0000000;
   localparam int         OPERAND_BITS = 10;

   typedef enum logic [1:0] {
      TOP_NONE  = 2'd0,
      TOP_SET   = 2'd1,
      TOP_CHECK = 2'd2
   } tag_op_e;

endpackage

// File: rtl/btag_decode.sv
module btag_decode
   import btag_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int SLOT_W  = 8,
   parameter int ID_W    = 2
) (
   input  logic               valid_i,
   input  logic               en_i,
   input  logic [INSTR_W-1:0] instr_i,
   output tag_op_e            op_o,
   output logic [ID_W-1:0]    id_o,
   output logic [SLOT_W-1:0]  value_o
);

   generate
      if (INSTR_W != 32) begin : g_bad_instr_w
         $error("btag_decode: INSTR_W must be 32");
      end
      if (ID_W + SLOT_W != OPERAND_BITS) begin : g_bad_operand_w
         $error("btag_decode: id and value must fill the 10 operand bits");
      end
   endgenerate

   logic [6:0] opcode;
   logic [4:0] rd;
   logic [2:0] funct3;
   logic [6:0] funct7;
   logic [OPERAND_BITS-1:0] operand;
   logic       base_ok;

   always_comb begin
      opcode  = instr_i[6:0];
      rd      = instr_i[11:7];
      funct3  = instr_i[14:12];
      funct7  = instr_i[31:25];
      // shamt field on top, rs1 field below
      operand = {instr_i[24:20], instr_i[19:15]};
      base_ok = valid_i && en_i && (opcode == OPC_IMM)
                && (rd == 5'd0) && (funct7 == F7_PLAIN);
   end

   always_comb begin
      op_o = TOP_NONE;
      if (base_ok) begin
         unique case (funct3)
            F3_SET:   op_o = TOP_SET;
            F3_CHECK: op_o = TOP_CHECK;
            default:  op_o = TOP_NONE;
         endcase
      end
   end

   assign id_o    = operand[OPERAND_BITS-1 -: ID_W];
   assign value_o = operand[SLOT_W-1:0];

endmodule

// File: rtl/btag_slots.sv
module btag_slots #(
   parameter int         NUM_SLOTS = 4,
   parameter int         SLOT_W    = 8,
   parameter int         ID_W      = 2,
   parameter logic [7:0] RST_TAG   = 8'h00,
   localparam int        CSR_W     = NUM_SLOTS * SLOT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [ID_W-1:0]   wr_id_i,
   input  logic [SLOT_W-1:0] wr_val_i,
   output logic [CSR_W-1:0]  slots_o
);

   generate
      if (NUM_SLOTS > (1 << ID_W)) begin : g_bad_slots
         $error("btag_slots: ID_W too narrow for NUM_SLOTS");
      end
      if (SLOT_W > 8) begin : g_bad_slot_w
         $error("btag_slots: RST_TAG only covers 8-bit slots");
      end
   endgenerate

   for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
      logic [SLOT_W-1:0] tag_q;
      logic              hit;

      assign hit = wr_en_i && (wr_id_i == ID_W'(gi));

      always_ff @(posedge clk) begin
         if (rst) begin
            tag_q <= RST_TAG[SLOT_W-1:0];
         end else if (hit) begin
            tag_q <= wr_val_i;
         end
      end

      assign slots_o[gi*SLOT_W +: SLOT_W] = tag_q;
   end

endmodule

// File: rtl/btag_compare.sv
module btag_compare #(
   parameter int NUM_SLOTS  = 4,
   parameter int SLOT_W     = 8,
   parameter int ID_W       = 2,
   parameter bit REG_RESULT = 1'b1,
   localparam int CSR_W     = NUM_SLOTS * SLOT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              chk_en_i,
   input  logic [ID_W-1:0]   chk_id_i,
   input  logic [SLOT_W-1:0] chk_val_i,
   input  logic [CSR_W-1:0]  slots_i,
   output logic              pass_o,
   output logic              fail_o
);

   logic [SLOT_W-1:0] sel_tag;
   logic              match;

   always_comb begin
      sel_tag = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (chk_id_i == ID_W'(k)) begin
            sel_tag = slots_i[k*SLOT_W +: SLOT_W];
         end
      end
      match = (sel_tag == chk_val_i);
   end

   generate
      if (REG_RESULT) begin : g_reg
         logic pass_q, fail_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               pass_q <= 1'b0;
               fail_q <= 1'b0;
            end else begin
               pass_q <= chk_en_i && match;
               fail_q <= chk_en_i && !match;
            end
         end
         assign pass_o = pass_q;
         assign fail_o = fail_q;
      end else begin : g_comb
         assign pass_o = chk_en_i && match;
         assign fail_o = chk_en_i && !match;
      end
   endgenerate

endmodule

// File: rtl/btag_unit.sv
module btag_unit
   import btag_pkg::*;
#(
   parameter int         NUM_SLOTS  = 4,
   parameter int         SLOT_W     = 8,
   parameter int         INSTR_W    = 32,
   parameter bit         REG_RESULT = 1'b1,
   parameter logic [7:0] RST_TAG    = 8'h00,
   localparam int        ID_W       = $clog2(NUM_SLOTS),
   localparam int        CSR_W      = NUM_SLOTS * SLOT_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ext_en,
   input  logic               retire_valid,
   input  logic [INSTR_W-1:0] retire_instr,
   output logic               chk_pass,
   output logic               chk_fail,
   output logic [CSR_W-1:0]   tag_csr
);

   generate
      if (CSR_W != 32) begin : g_bad_csr_w
         $error("btag_unit: slots must fill a 32-bit register");
      end
   endgenerate

   tag_op_e           op;
   logic [ID_W-1:0]   op_id;
   logic [SLOT_W-1:0] op_val;
   logic              do_set;
   logic              do_check;

   btag_decode #(
      .INSTR_W (INSTR_W),
      .SLOT_W  (SLOT_W),
      .ID_W    (ID_W)
   ) dec_i (
      .valid_i (retire_valid),
      .en_i    (ext_en),
      .instr_i (retire_instr),
      .op_o    (op),
      .id_o    (op_id),
      .value_o (op_val)
   );

   assign do_set   = (op == TOP_SET);
   assign do_check = (op == TOP_CHECK);

   btag_slots #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_W    (SLOT_W),
      .ID_W      (ID_W),
      .RST_TAG   (RST_TAG)
   ) slots_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en_i  (do_set),
      .wr_id_i  (op_id),
      .wr_val_i (op_val),
      .slots_o  (tag_csr)
   );

   btag_compare #(
      .NUM_SLOTS  (NUM_SLOTS),
      .SLOT_W     (SLOT_W),
      .ID_W       (ID_W),
      .REG_RESULT (REG_RESULT)
   ) cmp_i (
      .clk       (clk),
      .rst       (rst),
      .chk_en_i  (do_check),
      .chk_id_i  (op_id),
      .chk_val_i (op_val),
      .slots_i   (tag_csr),
      .pass_o    (chk_pass),
      .fail_o    (chk_fail)
   );

endmodule

// File: rtl/btag_unit_chk.sv
module btag_unit_chk #(
   parameter int CSR_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             ext_en,
   input logic             retire_valid,
   input logic             chk_pass,
   input logic             chk_fail,
   input logic [CSR_W-1:0] tag_csr
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (tag_csr == '0) && !chk_pass && !chk_fail);

   // R10
   excl_result_chk: assert property (@(posedge clk) disable iff (rst)
      !(chk_pass && chk_fail));

   // R7
   idle_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
      !retire_valid |=> $stable(tag_csr) && !chk_pass && !chk_fail);

   // R6
   disabled_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
      !ext_en |=> $stable(tag_csr) && !chk_pass && !chk_fail);

   // R4
   fail_keeps_slots_chk: assert property (@(posedge clk) disable iff (rst)
      chk_fail |-> $stable(tag_csr));

   // R3
   pass_keeps_slots_chk: assert property (@(posedge clk) disable iff (rst)
      chk_pass |-> $stable(tag_csr));

   // R10
   pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
      (chk_pass || chk_fail) |-> $past(retire_valid) && $past(ext_en));

endmodule

bind btag_unit btag_unit_chk #(.CSR_W(32)) chk_i (
   .clk          (clk),
   .rst          (rst),
   .ext_en       (ext_en),
   .retire_valid (retire_valid),
   .chk_pass     (chk_pass),
   .chk_fail     (chk_fail),
   .tag_csr      (tag_csr)
);

// File: tb/btag_unit_tb_top.sv
module btag_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ext_en = 1'b0;
   logic        retire_valid = 1'b0;
   logic [31:0] retire_instr = 32'h0;
   logic        chk_pass;
   logic        chk_fail;
   logic [31:0] tag_csr;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   btag_unit dut_i (
      .clk          (clk),
      .rst          (rst),
      .ext_en       (ext_en),
      .retire_valid (retire_valid),
      .retire_instr (retire_instr),
      .chk_pass     (chk_pass),
      .chk_fail     (chk_fail),
      .tag_csr      (tag_csr)
   );

   // Field layout from R2, R3, R9: f7 | id | val[7:5] | val[4:0] | f3 | rd | opcode
   function automatic logic [31:0] enc(input logic [6:0] f7, input logic [1:0] id,
                                       input logic [7:0] val, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc);
      return {f7, id, val[7:5], val[4:0], f3, rd, opc};
   endfunction

   function automatic logic [31:0] hset(input logic [1:0] id, input logic [7:0] val);
      return enc(7'h00, id, val, 3'b001, 5'd0, 7'b0010011);
   endfunction

   function automatic logic [31:0] hchk(input logic [1:0] id, input logic [7:0] val);
      return enc(7'h00, id, val, 3'b101, 5'd0, 7'b0010011);
   endfunction

   typedef struct packed {
      logic        v;
      logic        en;
      logic [31:0] ins;
      logic        xp;
      logic        xf;
      logic [31:0] xcsr;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b1, hset(2'd0, 8'h11), 1'b0, 1'b0, 32'h0000_0011, 4'd2},  // R2
      '{1'b1, 1'b1, hchk(2'd0, 8'h11), 1'b1, 1'b0, 32'h0000_0011, 4'd3},  // R3
      '{1'b1, 1'b1, hset(2'd2, 8'hA5), 1'b0, 1'b0, 32'h00A5_0011, 4'd9},  // R9
      '{1'b1, 1'b1, hchk(2'd2, 8'hA4), 1'b0, 1'b1, 32'h00A5_0011, 4'd4},  // R4
      '{1'b1, 1'b1, enc(7'h00, 2'd1, 8'h3C, 3'b001, 5'd5, 7'b0010011),
                                       1'b0, 1'b0, 32'h00A5_0011, 4'd5},  // R5 rd!=0
      '{1'b1, 1'b1, enc(7'h20, 2'd1, 8'h00, 3'b101, 5'd0, 7'b0010011),
                                       1'b0, 1'b0, 32'h00A5_0011, 4'd5},  // R5 srai
      '{1'b1, 1'b0, hset(2'd3, 8'hFF), 1'b0, 1'b0, 32'h00A5_0011, 4'd6},  // R6
      '{1'b1, 1'b0, hchk(2'd0, 8'h22), 1'b0, 1'b0, 32'h00A5_0011, 4'd6},  // R6
      '{1'b0, 1'b1, hset(2'd3, 8'hFF), 1'b0, 1'b0, 32'h00A5_0011, 4'd7},  // R7
      '{1'b1, 1'b1, hset(2'd3, 8'h80), 1'b0, 1'b0, 32'h80A5_0011, 4'd2},  // R2
      '{1'b1, 1'b1, hchk(2'd3, 8'h80), 1'b1, 1'b0, 32'h80A5_0011, 4'd8},  // R8
      '{1'b1, 1'b1, hchk(2'd1, 8'h00), 1'b1, 1'b0, 32'h80A5_0011, 4'd3},  // R3
      '{1'b1, 1'b1, hset(2'd0, 8'h5A), 1'b0, 1'b0, 32'h80A5_005A, 4'd2},  // R2
      '{1'b1, 1'b1, hchk(2'd0, 8'h11), 1'b0, 1'b1, 32'h80A5_005A, 4'd8},  // R8 stale
      '{1'b1, 1'b1, hchk(2'd0, 8'h5A), 1'b1, 1'b0, 32'h80A5_005A, 4'd3},  // R3
      '{1'b1, 1'b1, enc(7'h00, 2'd0, 8'h5A, 3'b101, 5'd0, 7'b0110011),
                                       1'b0, 1'b0, 32'h80A5_005A, 4'd10}, // R10 / R5 opcode
      '{1'b1, 1'b1, enc(7'h01, 2'd1, 8'h77, 3'b001, 5'd0, 7'b0010011),
                                       1'b0, 1'b0, 32'h80A5_005A, 4'd5}   // R5 funct7
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while and right after reset
      check("R1", "csr", tag_csr, 32'h0);
      check("R1", "pass", {31'b0, chk_pass}, 32'h0);
      check("R1", "fail", {31'b0, chk_fail}, 32'h0);
      rst = 1'b0;
      ext_en = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d[v%0d]", VEC[i].req, i);
         retire_valid = VEC[i].v;
         ext_en       = VEC[i].en;
         retire_instr = VEC[i].ins;
         @(negedge clk);
         check(tag, "pass", {31'b0, chk_pass}, {31'b0, VEC[i].xp});
         check(tag, "fail", {31'b0, chk_fail}, {31'b0, VEC[i].xf});
         check(tag, "csr",  tag_csr, VEC[i].xcsr);
      end

      // R10: a pass pulse lasts one cycle only
      retire_valid = 1'b1;
      ext_en = 1'b1;
      retire_instr = hchk(2'd3, 8'h80);
      @(negedge clk);
      retire_valid = 1'b0;
      check("R10", "pass first", {31'b0, chk_pass}, 32'h1);
      @(negedge clk);
      check("R10", "pass second", {31'b0, chk_pass}, 32'h0);
      check("R10", "fail second", {31'b0, chk_fail}, 32'h0);

      // R8: set then check to a fresh value on slot 1, back to back
      retire_valid = 1'b1;
      retire_instr = hset(2'd1, 8'hC3);
      @(negedge clk);
      retire_instr = hchk(2'd1, 8'hC3);
      @(negedge clk);
      retire_valid = 1'b0;
      check("R8", "pass", {31'b0, chk_pass}, 32'h1);
      check("R8", "csr", tag_csr, 32'h80A5_C35A);

      // R1: reset in the middle of a run clears all slots
      rst = 1'b1;
      @(negedge clk);
      check("R1", "csr after rerun reset", tag_csr, 32'h0);
      rst = 1'b0;
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

endmodule